// File: doc/BRIEF.md
# ECC Write-Path Fault Injector

This block sits between a memory controller's write queue and its DRAM interface. It passes each write beat through unchanged unless software has armed a fault. When a fault is armed, it flips bits of the ECC codeword on purpose so that the error-correction logic downstream can be tested. The codeword of a beat is a row of 16-bit symbols. Software can name up to two symbol positions, and each position gets its own 16-bit XOR pattern. A half-line selector restricts the corruption to the lower beat of a cache line, the upper beat, or both. Every output is registered, so the block adds one cycle of latency.

Each memory channel has its own pair of mask registers, and a channel select input picks which pair is in use. An 8-bit response register holds a start code and a stop code. A start code of 1011 arms the injector and any other start code disarms it. A stop code of 1011 makes injection continuous and any other stop code makes it one-shot. After a one-shot fault has fired, the injector stays dead until software writes a non-starting code and then the start code again. A one-cycle pulse and a sticky flag report each corrupted beat.

Top module: `ecc_fault_injector`

## Requirements
- R1: After reset, out_valid, out_data, inj_pulse and inj_done are all zero, and no injection is armed.
- R2: A beat that is not corrupted appears on out_data unchanged one cycle after it is presented, with out_valid high in that cycle and low after a cycle with no beat.
- R3: Mask-0 bits 29:28 pick the half-line: 01 hits beats with beat_upper=0, 10 hits beats with beat_upper=1, 11 hits both kinds, and 00 hits none.
- R4: On a corrupted beat, symbol k (out_data bits 16k+15:16k) is XORed with mask-0 bits 25:10 when k equals mask-0 bits 4:0, and with mask-1 bits 15:0 when k equals mask-0 bits 9:5. Both patterns apply when the two pointers are equal, and a pointer at or above the symbol count changes nothing.
- R5: No beat is corrupted while mask-0 bit 27 (enable) is 0.
- R6: A response write whose bits 3:0 equal 1011 arms injection. A response write with any other start code disarms it.
- R7: When response bits 7:4 equal 1011, every matching beat is corrupted. Any other stop code corrupts only the first matching beat after arming.
- R8: After a one-shot fault has fired, a write with start code 1011 does not re-arm. A write with a non-1011 start code must come first.
- R9: chan_sel picks which channel's mask pair is used. Writes addressed through cfg_chan to one channel leave the other channel's registers unchanged.
- R10: inj_pulse is high for exactly the one cycle in which a corrupted beat is on out_data. inj_done sets in that same cycle, stays set, and is cleared by a response write that does not coincide with a fault.
- R11: A beat presented in the same cycle as a register write is judged against the register contents from before that write. cfg_target values are 0 for mask-0, 1 for mask-1 and 2 for the response register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_target | input | 2 | Register select: 0 mask-0, 1 mask-1, 2 response |
| cfg_chan | input | CH_W | Channel addressed by a mask write |
| cfg_wdata | input | 32 | Write data |
| chan_sel | input | CH_W | Channel whose masks drive corruption |
| beat_valid | input | 1 | Write beat present |
| beat_upper | input | 1 | 1 for the upper half of the cache line, 0 for the lower half |
| beat_data | input | NSYM*16 | Codeword of the beat |
| out_valid | output | 1 | Registered beat present |
| out_data | output | NSYM*16 | Registered, possibly corrupted codeword |
| inj_pulse | output | 1 | This output beat was corrupted |
| inj_done | output | 1 | Sticky flag: a fault has been injected |

## Verification
Two things can land in the same clock edge: a write beat that is being corrupted, and a register write that changes the trigger, in particular a response write that disarms injection or a mask write that clears the enable bit. The bench drives the beat and the write in the same cycle. It then expects the beat to be corrupted under the old settings and the following beat to pass through clean. A one-shot fault that fires in the same cycle as a start write is covered by an assertion: the start write must not re-arm injection.

// File: rtl/ecc_inj_pkg.sv
`timescale 1ns/1ps
package ecc_inj_pkg;
  localparam int SYM_W = 16;
  localparam int PTR_W = 5;

  localparam logic [1:0] TGT_MASK0 = 2'd0;
  localparam logic [1:0] TGT_MASK1 = 2'd1;
  localparam logic [1:0] TGT_RESP  = 2'd2;

  // 1011 means "start now" as a start code and "never stop" as a stop code
  localparam logic [3:0] CODE_GO = 4'b1011;

  function automatic logic code_go(input logic [3:0] code);
    return code == CODE_GO;
  endfunction

  function automatic logic half_hit(input logic [1:0] hsel, input logic upper);
    case (hsel)
      2'b01:   return !upper;
      2'b10:   return upper;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/inj_regfile.sv
`timescale 1ns/1ps
module inj_regfile import ecc_inj_pkg::*; #(
  parameter  int NCH  = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_target,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic [31:0]     cfg_wdata,
  input  logic [CH_W-1:0] chan_sel,
  output logic [31:0]     mask0_sel,
  output logic [15:0]     mask1_sel,
  output logic [7:0]      resp_q,
  output logic            resp_wr
);
  logic [NCH-1:0][31:0] m0_all;
  logic [NCH-1:0][15:0] m1_all;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [31:0] m0_r;
    logic [15:0] m1_r;
    logic        hit;
    assign hit = cfg_we && (32'(cfg_chan) == c);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        m0_r <= '0;
        m1_r <= '0;
      end else begin
        if (hit && cfg_target == TGT_MASK0) m0_r <= cfg_wdata;
        if (hit && cfg_target == TGT_MASK1) m1_r <= cfg_wdata[15:0];
      end
    end
    assign m0_all[c] = m0_r;
    assign m1_all[c] = m1_r;
  end

  assign resp_wr = cfg_we && (cfg_target == TGT_RESP);

  always_ff @(posedge clk) begin
    if (!rst_n)       resp_q <= '0;
    else if (resp_wr) resp_q <= cfg_wdata[7:0];
  end

  assign mask0_sel = m0_all[chan_sel];
  assign mask1_sel = m1_all[chan_sel];
endmodule

// File: rtl/inj_trigger.sv
`timescale 1ns/1ps
module inj_trigger import ecc_inj_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       resp_wr,
  input  logic [3:0] start_code_wr,
  input  logic [3:0] stop_code,
  input  logic       fire,
  output logic       running,
  output logic       spent,
  output logic       oneshot,
  output logic       done
);
  logic run_d, spent_d, oneshot_fire;

  assign oneshot      = !code_go(stop_code);
  assign oneshot_fire = fire && oneshot;

  always_comb begin
    run_d   = running;
    spent_d = spent;
    if (oneshot_fire) begin
      run_d   = 1'b0;
      spent_d = 1'b1;
    end
    if (resp_wr) begin
      if (!code_go(start_code_wr)) begin
        run_d   = 1'b0;
        spent_d = 1'b0;
      end else if (!spent && !oneshot_fire) begin
        run_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      spent   <= 1'b0;
      done    <= 1'b0;
    end else begin
      running <= run_d;
      spent   <= spent_d;
      if (fire)         done <= 1'b1;
      else if (resp_wr) done <= 1'b0;
    end
  end
endmodule

// File: rtl/inj_corrupt.sv
`timescale 1ns/1ps
module inj_corrupt import ecc_inj_pkg::*; #(
  parameter  int NSYM = 8,
  localparam int DW   = NSYM * SYM_W
) (
  input  logic             apply,
  input  logic [PTR_W-1:0] ptr_a,
  input  logic [PTR_W-1:0] ptr_b,
  input  logic [SYM_W-1:0] xor_a,
  input  logic [SYM_W-1:0] xor_b,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout
);
  for (genvar k = 0; k < NSYM; k++) begin : g_sym
    logic hit_a, hit_b;
    assign hit_a = apply && (32'(ptr_a) == k);
    assign hit_b = apply && (32'(ptr_b) == k);
    assign dout[k*SYM_W +: SYM_W] = din[k*SYM_W +: SYM_W]
                                  ^ (hit_a ? xor_a : '0)
                                  ^ (hit_b ? xor_b : '0);
  end
endmodule

// File: rtl/ecc_fault_injector.sv
`timescale 1ns/1ps
module ecc_fault_injector import ecc_inj_pkg::*; #(
  parameter  int NCH  = 2,
  parameter  int NSYM = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DW   = NSYM * SYM_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_target,
  input  logic [CH_W-1:0] cfg_chan,
  input  logic [31:0]     cfg_wdata,
  input  logic [CH_W-1:0] chan_sel,
  input  logic            beat_valid,
  input  logic            beat_upper,
  input  logic [DW-1:0]   beat_data,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic            inj_pulse,
  output logic            inj_done
);
  logic [31:0]   mask0_sel;
  logic [15:0]   mask1_sel;
  logic [7:0]    resp_q;
  logic          resp_wr;
  logic          running, spent, oneshot, fire;
  logic [DW-1:0] corrupt_data;
  logic          unused_bits;

  // address-match enable and reserved bits are held but not acted on
  assign unused_bits = ^{mask0_sel[31:30], mask0_sel[26], resp_q[3:0]};

  inj_regfile #(.NCH(NCH)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_target, .cfg_chan, .cfg_wdata, .chan_sel,
    .mask0_sel, .mask1_sel, .resp_q, .resp_wr
  );

  assign fire = beat_valid && running && mask0_sel[27]
             && half_hit(mask0_sel[29:28], beat_upper);

  inj_trigger u_trig (
    .clk, .rst_n, .resp_wr,
    .start_code_wr (cfg_wdata[3:0]),
    .stop_code     (resp_q[7:4]),
    .fire, .running, .spent, .oneshot,
    .done          (inj_done)
  );

  inj_corrupt #(.NSYM(NSYM)) u_xor (
    .apply (fire),
    .ptr_a (mask0_sel[4:0]),
    .ptr_b (mask0_sel[9:5]),
    .xor_a (mask0_sel[25:10]),
    .xor_b (mask1_sel),
    .din   (beat_data),
    .dout  (corrupt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      inj_pulse <= 1'b0;
    end else begin
      out_valid <= beat_valid;
      inj_pulse <= fire;
      if (beat_valid) out_data <= corrupt_data;
    end
  end
endmodule

// File: rtl/ecc_fault_injector_chk.sv
`timescale 1ns/1ps
module ecc_fault_injector_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fire,
  input logic          running,
  input logic          spent,
  input logic          oneshot,
  input logic          resp_wr,
  input logic [3:0]    start_code_wr,
  input logic          beat_valid,
  input logic [DW-1:0] beat_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          inj_pulse,
  input logic          inj_done
);
  a_r2_clean_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !fire) |=> (out_valid && out_data == $past(beat_data) && !inj_pulse));

  a_r10_pulse_and_done: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (inj_pulse && inj_done));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_done && !resp_wr) |=> inj_done);

  a_r7_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && oneshot) |=> !running);

  a_r8_spent_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    spent |=> !running);

  a_r6_nostart_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_wr && start_code_wr != 4'b1011) |=> !running);

  a_r3_fire_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (beat_valid && running));
endmodule

bind ecc_fault_injector ecc_fault_injector_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fire          (fire),
  .running       (running),
  .spent         (spent),
  .oneshot       (oneshot),
  .resp_wr       (resp_wr),
  .start_code_wr (cfg_wdata[3:0]),
  .beat_valid    (beat_valid),
  .beat_data     (beat_data),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .inj_pulse     (inj_pulse),
  .inj_done      (inj_done)
);

// File: tb/sim_ecc_fault_injector.sv
`timescale 1ns/1ps
module sim_ecc_fault_injector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_target = 2'd0;
  logic         cfg_chan = 1'b0;
  logic [31:0]  cfg_wdata = '0;
  logic         chan_sel = 1'b0;
  logic         beat_valid = 1'b0;
  logic         beat_upper = 1'b0;
  logic [127:0] beat_data = '0;
  logic         out_valid, inj_pulse, inj_done;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ecc_fault_injector u0 (
    .clk, .rst_n, .cfg_we, .cfg_target, .cfg_chan, .cfg_wdata, .chan_sel,
    .beat_valid, .beat_upper, .beat_data, .out_valid, .out_data,
    .inj_pulse, .inj_done
  );

  typedef struct packed {
    logic [31:0]  m0;
    logic [15:0]  m1;
    logic         ch;
    logic         upper;
    logic [127:0] d;
  } vec_t;

  localparam vec_t VEC [8] = '{
    {32'h1803_FC61, 16'hF0F0, 1'b0, 1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210},
    {32'h2A96_9442, 16'h0F0F, 1'b0, 1'b1, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555},
    {32'h3BFF_FCE0, 16'h1234, 1'b0, 1'b0, 128'h0},
    {32'h1803_FC61, 16'hF0F0, 1'b0, 1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    {32'h0803_FC61, 16'hF0F0, 1'b0, 1'b0, 128'h1357_9BDF_2468_ACE0_1357_9BDF_2468_ACE0},
    {32'h3003_FC61, 16'hF0F0, 1'b0, 1'b0, 128'hA5A5_5A5A_A5A5_5A5A_A5A5_5A5A_A5A5_5A5A},
    {32'h3803_FC09, 16'h8001, 1'b0, 1'b1, 128'h0F0F_F0F0_0F0F_F0F0_0F0F_F0F0_0F0F_F0F0},
    {32'h9800_0485, 16'hFFFF, 1'b1, 1'b0, 128'hCAFE_F00D_CAFE_F00D_1234_5678_9ABC_DEF0}
  };
  localparam string TAG [8] = '{"R4", "R4", "R3", "R3", "R3", "R5", "R4", "R9"};

  // restated model: hsel bit 1 admits upper beats, bit 0 admits lower beats
  function automatic logic [127:0] model(input logic [31:0] m0, input logic [15:0] m1,
                                         input logic upper, input logic [127:0] d,
                                         output logic hit);
    logic [127:0] r;
    int pa, pb;
    r   = d;
    pa  = int'(m0[4:0]);
    pb  = int'(m0[9:5]);
    hit = m0[27] && ((upper && m0[29]) || (!upper && m0[28]));
    if (hit) begin
      if (pa < 8) r = r ^ ({112'b0, m0[25:10]} << (16 * pa));
      if (pb < 8) r = r ^ ({112'b0, m1} << (16 * pb));
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a negative edge
  task automatic wr(input logic [1:0] t, input logic ch, input logic [31:0] d);
    cfg_we = 1'b1; cfg_target = t; cfg_chan = ch; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic beat(input logic up, input logic [127:0] d);
    beat_valid = 1'b1; beat_upper = up; beat_data = d;
    @(negedge clk);
    beat_valid = 1'b0;
  endtask

  localparam logic [31:0] DM0 = 32'h1803_FC61;
  localparam logic [15:0] DM1 = 16'hF0F0;
  localparam logic [127:0] DD = 128'h1111_2222_3333_4444_5555_6666_7777_8888;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] exp_d;
    logic         exp_hit;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!out_valid && !inj_pulse && !inj_done, "R1 flags", {125'b0, out_valid, inj_pulse, inj_done}, 128'h0);
    chk(out_data == '0, "R1 data", out_data, 128'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: nothing armed, beat passes through
    beat(1'b0, DD);
    chk(out_valid && out_data == DD && !inj_pulse, "R2 passthru", out_data, DD);
    @(negedge clk);
    chk(!out_valid, "R2 valid drop", {127'b0, out_valid}, 128'h0);

    // table walk: continuous mode, one vector per beat
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VEC[i];
      wr(ecc_inj_pkg::TGT_MASK0, !v.ch, 32'h3BFF_FC20);
      wr(ecc_inj_pkg::TGT_MASK1, !v.ch, 32'h0000_FFFF);
      wr(ecc_inj_pkg::TGT_MASK0, v.ch, v.m0);
      wr(ecc_inj_pkg::TGT_MASK1, v.ch, {16'h0, v.m1});
      chan_sel = v.ch;
      wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hAA);
      wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hBB);
      exp_d = model(v.m0, v.m1, v.upper, v.d, exp_hit);
      beat(v.upper, v.d);
      chk(out_data == exp_d, TAG[i], out_data, exp_d);
      chk(inj_pulse == exp_hit, "R10 pulse vs table", {127'b0, inj_pulse}, {127'b0, exp_hit});
    end

    // directed: one-shot on channel 0
    chan_sel = 1'b0;
    wr(ecc_inj_pkg::TGT_MASK0, 1'b0, DM0);
    wr(ecc_inj_pkg::TGT_MASK1, 1'b0, {16'h0, DM1});
    exp_d = model(DM0, DM1, 1'b0, DD, exp_hit);
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hAA);
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hAB);
    chk(!inj_done, "R10 done cleared by resp write", {127'b0, inj_done}, 128'h0);
    beat(1'b0, DD);
    chk(out_data == exp_d && inj_pulse && inj_done, "R7 oneshot fires", out_data, exp_d);
    @(negedge clk);
    chk(!inj_pulse, "R10 pulse one cycle", {127'b0, inj_pulse}, 128'h0);
    beat(1'b0, DD);
    chk(out_data == DD && !inj_pulse, "R7 oneshot stops", out_data, DD);
    chk(inj_done, "R10 done sticky", {127'b0, inj_done}, 128'h1);

    // R8: start again without the never-start write does nothing
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hAB);
    beat(1'b0, DD);
    chk(out_data == DD && !inj_pulse, "R8 no rearm", out_data, DD);
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hAA);
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hAB);
    beat(1'b0, DD);
    chk(out_data == exp_d && inj_pulse, "R8 rearm after toggle", out_data, exp_d);

    // R6: an odd start code disarms and also clears the spent state
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hB5);
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hBB);
    beat(1'b0, DD);
    chk(out_data == exp_d, "R6 start 1011 arms", out_data, exp_d);
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hB5);
    beat(1'b0, DD);
    chk(out_data == DD && !inj_pulse, "R6 odd start disarms", out_data, DD);

    // R7: an odd stop code behaves as one-shot
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'h5B);
    beat(1'b0, DD);
    chk(out_data == exp_d, "R7 odd stop first beat", out_data, exp_d);
    beat(1'b0, DD);
    chk(out_data == DD, "R7 odd stop halts", out_data, DD);

    // R11: disarming write in the same cycle as a matching beat
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hAA);
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hBB);
    cfg_we = 1'b1; cfg_target = ecc_inj_pkg::TGT_RESP; cfg_wdata = 32'hBA;
    beat_valid = 1'b1; beat_upper = 1'b0; beat_data = DD;
    @(negedge clk);
    cfg_we = 1'b0; beat_valid = 1'b0;
    chk(out_data == exp_d && inj_pulse, "R11 beat uses old resp", out_data, exp_d);
    chk(inj_done, "R10 fire beats resp clear", {127'b0, inj_done}, 128'h1);
    beat(1'b0, DD);
    chk(out_data == DD, "R11 disarm then effective", out_data, DD);

    // R11: mask write clearing enable in the same cycle as a beat
    wr(ecc_inj_pkg::TGT_RESP, 1'b0, 32'hBB);
    cfg_we = 1'b1; cfg_target = ecc_inj_pkg::TGT_MASK0; cfg_chan = 1'b0; cfg_wdata = 32'h0003_FC61;
    beat_valid = 1'b1; beat_upper = 1'b0; beat_data = DD;
    @(negedge clk);
    cfg_we = 1'b0; beat_valid = 1'b0;
    chk(out_data == exp_d, "R11 beat uses old mask", out_data, exp_d);
    beat(1'b0, DD);
    chk(out_data == DD, "R5 cleared enable", out_data, DD);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule